// File: doc/BRIEF.md
# Next-PC and Link Address Generator

This block is the purely combinational next-program-counter stage of a single-cycle 32-bit core. Every cycle it takes the current program counter, the decoded 16-bit offset and 26-bit word index from the instruction, the value read from a register, the result of the register comparison and a flow-mode code. It returns the address the core fetches next.

The block covers sequential flow, conditional branches relative to the program counter, region-local absolute jumps, calls and jumps through a register. For a call it also returns the return address and the number of the register that receives it, so the register file can write the link in the same cycle. The return address goes into a fixed register rather than onto a stack. A return is a jump through a register whose value the core has read from that fixed link register.

Top module: `npc_gen`

## Requirements
- R1: With mode code 0 (sequential), `next_pc_o` equals `pc_i + 4`, wrapping modulo 2^32.
- R2: With mode code 1 (branch) and `eq_i` high, `next_pc_o` equals `pc_i + 4` plus the sign-extended `imm_i` shifted left by two bits.
- R3: With mode code 1 (branch) and `eq_i` low, `next_pc_o` equals `pc_i + 4`.
- R4: With mode code 2 (jump), `next_pc_o` is bits 31..28 of `pc_i + 4` followed by `jidx_i` and two zero bits. A word index of 2500 in the lowest region gives byte address 10000.
- R5: With mode code 3 (call), `next_pc_o` is the same target as in R4. `link_we_o` is 1, `link_val_o` is `pc_i + 4` and `link_idx_o` is 31.
- R6: With mode code 4 (register jump), `next_pc_o` equals `rs_val_i` with all 32 bits unchanged.
- R7: For every mode code other than 3, `link_we_o` is 0 and `link_idx_o` is 0. `link_val_o` always carries `pc_i + 4`.
- R8: Mode codes 5, 6 and 7 are reserved and behave as sequential flow.
- R9: `eq_i` has no effect on any output unless the mode code is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pc_i | input | 32 | Current program counter |
| imm_i | input | 16 | Signed branch offset in words |
| jidx_i | input | 26 | Jump word index |
| rs_val_i | input | 32 | Register value for a register jump |
| eq_i | input | 1 | Branch compare result, high when equal |
| mode_i | input | 3 | Flow mode code |
| next_pc_o | output | 32 | Next program counter |
| link_we_o | output | 1 | Write enable for the link register |
| link_val_o | output | 32 | Return address (PC+4) |
| link_idx_o | output | 5 | Link register number (31 on a call, else 0) |

## Verification
A call makes two results at once: the jump target on `next_pc_o` and the return-address write on the link outputs. Both come from the same `pc_i + 4`. The bench provokes this overlap with calls from program counters just below a 256 MB boundary, where adding 4 moves the upper nibble into the next region. Both outputs are then judged in the same sample against values computed in the bench. Random vectors also pair every mode with both compare values, which confirms that the compare result only steers branches.

// File: rtl/npc_pkg.sv
package npc_pkg;
    localparam int XLEN     = 32;
    localparam int IMM_W    = 16;
    localparam int JIDX_W   = 26;
    localparam int RIDX_W   = 5;
    localparam int LINK_REG = 31;
    localparam int MODE_W   = 3;
    localparam int INSN_BYTES = 4;

    typedef enum logic [MODE_W-1:0] {
        NPC_SEQ  = 3'd0,
        NPC_BR   = 3'd1,
        NPC_JMP  = 3'd2,
        NPC_CALL = 3'd3,
        NPC_JREG = 3'd4
    } npc_mode_e;

    typedef struct packed {
        logic [XLEN-1:0] br_tgt;
        logic [XLEN-1:0] jmp_tgt;
    } npc_tgts_t;

    function automatic logic is_region_jump(npc_mode_e m);
        return (m == NPC_JMP) || (m == NPC_CALL);
    endfunction
endpackage

// File: rtl/npc_incr.sv
module npc_incr #(
    parameter int XLEN = 32,
    parameter int STEP = 4
) (
    input  logic [XLEN-1:0] pc_i,
    output logic [XLEN-1:0] pc_step_o
);
    localparam logic [XLEN-1:0] STEP_V = XLEN'(STEP);

    assign pc_step_o = pc_i + STEP_V;
endmodule

// File: rtl/npc_targets.sv
module npc_targets
    import npc_pkg::*;
#(
    parameter int W     = XLEN,
    parameter int IW    = IMM_W,
    parameter int JW    = JIDX_W
) (
    input  logic [W-1:0]  pc4_i,
    input  logic [IW-1:0] imm_i,
    input  logic [JW-1:0] jidx_i,
    output npc_tgts_t     tgts_o
);
    localparam int EXT_W = W - IW - 2;
    localparam int HI_W  = W - JW - 2;

    logic [W-1:0] offs;

    generate
        if (EXT_W > 0) begin : g_sext
            assign offs = {{EXT_W{imm_i[IW-1]}}, imm_i, 2'b00};
        end else begin : g_nosext
            assign offs = W'({imm_i, 2'b00});
        end
    endgenerate

    always_comb begin
        tgts_o.br_tgt  = pc4_i + offs;
        tgts_o.jmp_tgt = {pc4_i[W-1 -: HI_W], jidx_i, 2'b00};
    end

    // R2: branch target stays word aligned whenever the base is aligned
    always_comb begin
        if (pc4_i[1:0] == 2'b00)
            a_r2_br_aligned: assert (tgts_o.br_tgt[1:0] == 2'b00);
    end

    // R4: region jump keeps upper bits of the incremented PC
    always_comb begin
        a_r4_region_kept: assert (tgts_o.jmp_tgt[W-1 -: HI_W] == pc4_i[W-1 -: HI_W]
                                  && tgts_o.jmp_tgt[1:0] == 2'b00);
    end
endmodule

// File: rtl/npc_select.sv
module npc_select
    import npc_pkg::*;
#(
    parameter int W = XLEN
) (
    input  npc_mode_e    mode_i,
    input  logic         eq_i,
    input  logic [W-1:0] pc4_i,
    input  npc_tgts_t    tgts_i,
    input  logic [W-1:0] rs_val_i,
    output logic [W-1:0] next_pc_o,
    output logic         link_we_o
);
    always_comb begin
        next_pc_o = pc4_i;
        link_we_o = 1'b0;
        unique case (mode_i)
            NPC_BR:   next_pc_o = eq_i ? tgts_i.br_tgt : pc4_i;
            NPC_JMP:  next_pc_o = tgts_i.jmp_tgt;
            NPC_CALL: begin
                next_pc_o = tgts_i.jmp_tgt;
                link_we_o = 1'b1;
            end
            NPC_JREG: next_pc_o = rs_val_i;
            default:  next_pc_o = pc4_i;
        endcase
    end

    // R3: untaken branch falls through
    always_comb begin
        if (mode_i == NPC_BR && !eq_i)
            a_r3_fallthrough: assert (next_pc_o == pc4_i);
    end

    // R6: register jump passes the register value through
    always_comb begin
        if (mode_i == NPC_JREG)
            a_r6_reg_target: assert (next_pc_o == rs_val_i);
    end
endmodule

// File: rtl/npc_gen.sv
module npc_gen
    import npc_pkg::*;
#(
    parameter int W      = XLEN,
    parameter int IW     = IMM_W,
    parameter int JW     = JIDX_W,
    parameter int RW     = RIDX_W,
    parameter int LREG   = LINK_REG
) (
    input  logic [W-1:0]      pc_i,
    input  logic [IW-1:0]     imm_i,
    input  logic [JW-1:0]     jidx_i,
    input  logic [W-1:0]      rs_val_i,
    input  logic              eq_i,
    input  logic [MODE_W-1:0] mode_i,
    output logic [W-1:0]      next_pc_o,
    output logic              link_we_o,
    output logic [W-1:0]      link_val_o,
    output logic [RW-1:0]     link_idx_o
);
    localparam logic [RW-1:0] LREG_V = RW'(LREG);

    npc_mode_e    mode;
    logic [W-1:0] pc4;
    npc_tgts_t    tgts;

    assign mode = npc_mode_e'(mode_i);

    npc_incr #(.XLEN(W), .STEP(INSN_BYTES)) u_incr (
        .pc_i      (pc_i),
        .pc_step_o (pc4)
    );

    npc_targets #(.W(W), .IW(IW), .JW(JW)) u_tgts (
        .pc4_i  (pc4),
        .imm_i  (imm_i),
        .jidx_i (jidx_i),
        .tgts_o (tgts)
    );

    npc_select #(.W(W)) u_sel (
        .mode_i    (mode),
        .eq_i      (eq_i),
        .pc4_i     (pc4),
        .tgts_i    (tgts),
        .rs_val_i  (rs_val_i),
        .next_pc_o (next_pc_o),
        .link_we_o (link_we_o)
    );

    assign link_val_o = pc4;
    assign link_idx_o = link_we_o ? LREG_V : '0;

    // R7: link write only ever comes from a call
    always_comb begin
        if (link_we_o)
            a_r7_link_only_call: assert (mode_i == MODE_W'(NPC_CALL));
    end

    // R5: a call's link value is the sequential successor of the PC
    always_comb begin
        if (link_we_o)
            a_r5_call_link: assert (link_val_o - pc_i == W'(INSN_BYTES)
                                    && is_region_jump(mode));
    end

    // R8: reserved codes never redirect flow or write a link
    always_comb begin
        if (mode_i > MODE_W'(NPC_JREG))
            a_r8_reserved_seq: assert (next_pc_o == link_val_o && !link_we_o);
    end
endmodule

// File: tb/npc_gen_tb.sv
module npc_gen_tb;
    logic        clk = 1'b0;
    logic [31:0] pc, rs;
    logic [15:0] imm;
    logic [25:0] jidx;
    logic        eq;
    logic [2:0]  mode;
    logic [31:0] next_pc, link_val;
    logic        link_we;
    logic [4:0]  link_idx;
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    npc_gen u_dut (
        .pc_i(pc), .imm_i(imm), .jidx_i(jidx), .rs_val_i(rs), .eq_i(eq),
        .mode_i(mode), .next_pc_o(next_pc), .link_we_o(link_we),
        .link_val_o(link_val), .link_idx_o(link_idx)
    );

    function automatic logic [31:0] exp_next(logic [31:0] p, logic [15:0] im,
                                             logic [25:0] j, logic [31:0] r,
                                             logic e, logic [2:0] m);
        logic [31:0] p4 = p + 32'd4;
        case (m)
            3'd1:    return e ? p4 + {{14{im[15]}}, im, 2'b00} : p4;
            3'd2,
            3'd3:    return {p4[31:28], j, 2'b00};
            3'd4:    return r;
            default: return p4;
        endcase
    endfunction

    function automatic string req_of(logic [2:0] m, logic e);
        case (m)
            3'd0: return "R1";
            3'd1: return e ? "R2" : "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            default: return "R8";
        endcase
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic apply(logic [31:0] p, logic [15:0] im, logic [25:0] j,
                         logic [31:0] r, logic e, logic [2:0] m);
        logic call;
        @(posedge clk);
        pc = p; imm = im; jidx = j; rs = r; eq = e; mode = m;
        @(negedge clk);
        call = (m == 3'd3);
        check(req_of(m, e), "next_pc", next_pc, exp_next(p, im, j, r, e, m));
        check(call ? "R5" : "R7", "link_we", {31'd0, link_we}, {31'd0, call});
        check(call ? "R5" : "R7", "link_idx", {27'd0, link_idx}, call ? 32'd31 : 32'd0);
        check("R7", "link_val", link_val, p + 32'd4);
    endtask

    // R9: toggle eq on a non-branch mode and see no change
    task automatic eq_ignored(logic [31:0] p, logic [2:0] m);
        logic [31:0] n0, v0;
        logic        w0;
        apply(p, 16'h8001, 26'h1234567, 32'hCAFE0001, 1'b0, m);
        n0 = next_pc; v0 = link_val; w0 = link_we;
        apply(p, 16'h8001, 26'h1234567, 32'hCAFE0001, 1'b1, m);
        check("R9", "next_pc eq-toggle", next_pc, n0);
        check("R9", "link_val eq-toggle", link_val, v0);
        check("R9", "link_we eq-toggle", {31'd0, link_we}, {31'd0, w0});
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd20240611));
        pc = 0; imm = 0; jidx = 0; rs = 0; eq = 0; mode = 0;
        // R1: plain and wrapping sequential flow
        apply(32'h0000_0000, 16'h0, 26'h0, 32'h0, 1'b0, 3'd0);
        apply(32'hFFFF_FFFC, 16'h0, 26'h0, 32'h0, 1'b1, 3'd0);
        // R2: forward, backward and extreme offsets
        apply(32'h0000_1000, 16'h0010, 26'h0, 32'h0, 1'b1, 3'd1);
        apply(32'h0000_1000, 16'hFFFF, 26'h0, 32'h0, 1'b1, 3'd1);
        apply(32'h0002_0000, 16'h8000, 26'h0, 32'h0, 1'b1, 3'd1);
        apply(32'h0000_0004, 16'h7FFF, 26'h0, 32'h0, 1'b1, 3'd1);
        // R3: untaken branch
        apply(32'h0000_1000, 16'h0010, 26'h0, 32'h0, 1'b0, 3'd1);
        // R4: word index 2500 lands on byte 10000
        apply(32'h0000_0100, 16'h0, 26'd2500, 32'h0, 1'b0, 3'd2);
        check("R4", "jump 2500", next_pc, 32'd10000);
        // R4/R5: region boundary, pc+4 crosses into next 256 MB region
        apply(32'h0FFF_FFFC, 16'h0, 26'h3FF_FFFF, 32'h0, 1'b0, 3'd2);
        apply(32'hEFFF_FFFC, 16'h0, 26'h000_0001, 32'h0, 1'b1, 3'd3);
        // R6: unaligned register value passes unchanged
        apply(32'h0040_0000, 16'h0, 26'h0, 32'h8000_0003, 1'b0, 3'd4);
        // R8: reserved codes
        for (int m = 5; m < 8; m++)
            apply(32'h1234_5670, 16'h0040, 26'h0ABCDEF, 32'h5555_AAAA, 1'b1, 3'(m));
        // R9: compare result ignored off-branch
        for (int m = 0; m < 8; m++)
            if (m != 1) eq_ignored(32'h3000_0FFC, 3'(m));
        // random mix of all modes
        for (int i = 0; i < 600; i++)
            apply($urandom, 16'($urandom), 26'($urandom), $urandom,
                  1'($urandom), 3'($urandom_range(0, 7)));
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule